// File: doc/BRIEF.md
# Framebuffer Register Port With Palette

This block is the processor-side register front end of a 640x400 framebuffer with four bits per pixel. Software reaches video memory through two independent word-address latches, one for reads and one for writes, and a single data register. Each access to the data register moves the latch it used forward by one word. Video memory is linear: eight pixels are packed into each 32-bit word, and each line is 80 words long. A small register set also loads a 16-slot colour palette with 12-bit RGB values and reports the display mode and the vertical-blank state.

The block drives the processor side of a video RAM. That side has a write channel and a registered read channel with one cycle of latency. The read channel is always pointed at the address the read latch will hold after the current edge, so the word behind the read latch is ready in the cycle it is read. This holds even for back-to-back reads. A write that lands on the word the read latch points at is forwarded to the data register for one cycle. The block also serves the scan-out side: given a packed video word and a pixel position, it returns that pixel's palette colour one cycle later.

The register bus uses word offsets. Offset 0 is the read address and offset 1 the write address. Offset 2 is the data port, offset 3 selects a palette slot, offset 4 writes palette colour and offset 5 is status.

Top module: `fb_reg_port`

## Requirements
- R1: After reset both address latches read back as 0, every palette slot holds 0, and a lookup of any pixel returns colour 0.
- R2: A read of offset 5 returns the mode value 1 in bits 31:28, the vblank input in bit 0 and zero in every other bit. A write to offset 5 changes nothing.
- R3: A read of offset 2 returns the word at the read address in the same cycle and then advances the read address by one. This also holds when offset 2 is read on every cycle.
- R4: A write to offset 2 stores the data word at the write address and then advances the write address by one. Any later read of that word returns the new value, including a read in the very next cycle when the read address points at it.
- R5: A write to offset 0 or offset 1 loads the read or the write address. A read of either offset returns that latch's current value. Word addressing is linear, so line n begins at word 80·n.
- R6: Both latches hold values from 0 to 31999. Advancing from 31999 gives 0, and loading any value of 32000 or more gives 0.
- R7: A write to offset 3 selects palette slot wdata[3:0]. A write to offset 4 stores wdata[11:0] in the selected slot, with red in 11:8, green in 7:4 and blue in 3:0. Reads of offsets 3, 4, 6 and 7 return 0.
- R8: One cycle after scanWord and scanPixSel are applied, pixRgb holds the palette colour of the selected pixel. Position 0 is bits 31:28 (the leftmost pixel), and position 7 is bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register word offset |
| regWr | input | 1 | Register write strobe; takes priority over regRd |
| regRd | input | 1 | Register read strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, valid in the cycle of the read |
| vblank | input | 1 | Vertical blank from the timing generator |
| vramWe | output | 1 | Video RAM write enable |
| vramWaddr | output | 15 | Video RAM write word address |
| vramWdata | output | 32 | Video RAM write data |
| vramRaddr | output | 15 | Video RAM read word address, sampled by the RAM each edge |
| vramRdata | input | 32 | Video RAM read data, one cycle after vramRaddr |
| scanWord | input | 32 | Packed video word from scan-out |
| scanPixSel | input | 3 | Pixel position within scanWord, 0 is leftmost |
| pixRgb | output | 12 | Palette colour of the selected pixel, registered |

## Verification
The bench uses a reduced frame of 32 words in four lines of eight words. It fills the whole frame with distinct words, then reads it back twice over on consecutive cycles. This separates correct prefetch from a read that lags by one word, and shows whether the latches wrap at the frame end. It then loads addresses at every line start, out of range, and at the same word as a pending write, which exposes a missing write forward. Finally, it sweeps every palette index through every pixel position inside words whose other nibbles differ, so a reversed nibble order or a wrong slot select shows up as a wrong colour.

// File: rtl/fbrp_pkg.sv
package fbrp_pkg;

  typedef enum logic [2:0] {
    OFS_RDADDR  = 3'd0,
    OFS_WRADDR  = 3'd1,
    OFS_DATA    = 3'd2,
    OFS_PALSEL  = 3'd3,
    OFS_PALDATA = 3'd4,
    OFS_STATUS  = 3'd5
  } regOfs_t;

  typedef struct packed {
    logic ldRdAddr;
    logic ldWrAddr;
    logic incRd;
    logic wrVram;
    logic ldPalSel;
    logic wrPal;
  } fbStrobes_t;

endpackage

// File: rtl/fbrp_ctrl.sv
module fbrp_ctrl
  import fbrp_pkg::*;
(
  input  logic       regWr,
  input  logic       regRd,
  input  logic [2:0] regAddr,
  output fbStrobes_t strobes
);

  logic rdEn;

  assign rdEn = regRd && !regWr;

  always_comb begin
    strobes = '0;
    if (regWr) begin
      case (regAddr)
        OFS_RDADDR:  strobes.ldRdAddr = 1'b1;
        OFS_WRADDR:  strobes.ldWrAddr = 1'b1;
        OFS_DATA:    strobes.wrVram   = 1'b1;
        OFS_PALSEL:  strobes.ldPalSel = 1'b1;
        OFS_PALDATA: strobes.wrPal    = 1'b1;
        default:     ;
      endcase
    end
    if (rdEn && regAddr == OFS_DATA) strobes.incRd = 1'b1;
  end

endmodule

// File: rtl/fbrp_palette.sv
module fbrp_palette #(
  parameter int IDX_W   = 4,
  parameter int COLOR_W = 12,
  localparam int PAL_N  = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               selLd,
  input  logic               entryWr,
  input  logic [IDX_W-1:0]   selValue,
  input  logic [COLOR_W-1:0] colorValue,
  input  logic [IDX_W-1:0]   lookIdx,
  output logic [COLOR_W-1:0] lookRgb
);

  logic [IDX_W-1:0] palSel;
  logic [PAL_N-1:0][COLOR_W-1:0] palMem;

  always_ff @(posedge clk) begin
    if (!rstN) palSel <= '0;
    else if (selLd) palSel <= selValue;
  end

  for (genvar e = 0; e < PAL_N; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) palMem[e] <= '0;
      else if (entryWr && palSel == IDX_W'(e)) palMem[e] <= colorValue;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lookRgb <= '0;
    else lookRgb <= palMem[lookIdx];
  end

  // R7: without a palette data write, no slot changes
  assert_pal_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !entryWr |=> $stable(palMem));

  // R7: the slot select moves only on a select write
  assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !selLd |=> $stable(palSel));

endmodule

// File: rtl/fbrp_datapath.sv
module fbrp_datapath
  import fbrp_pkg::*;
#(
  parameter int H_PIX   = 640,
  parameter int V_LINES = 400,
  parameter int BPP     = 4,
  parameter int DATA_W  = 32,
  parameter int COLOR_W = 12,
  parameter int MODE_ID = 1,
  localparam int PPW    = DATA_W / BPP,
  localparam int WPL    = H_PIX / PPW,
  localparam int FRAME  = WPL * V_LINES,
  localparam int AW     = $clog2(FRAME),
  localparam int SELW   = $clog2(PPW)
) (
  input  logic               clk,
  input  logic               rstN,
  input  fbStrobes_t         strobes,
  input  logic [2:0]         regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic               vblank,
  output logic               vramWe,
  output logic [AW-1:0]      vramWaddr,
  output logic [DATA_W-1:0]  vramWdata,
  output logic [AW-1:0]      vramRaddr,
  input  logic [DATA_W-1:0]  vramRdata,
  input  logic [DATA_W-1:0]  scanWord,
  input  logic [SELW-1:0]    scanPixSel,
  output logic [COLOR_W-1:0] pixRgb
);

  logic [AW-1:0]     rdAddr, wrAddr, rdAddrNext, wrAddrNext, loadVal;
  logic              bypassValid;
  logic [DATA_W-1:0] bypassWord, statusWord, scanShifted;
  logic [BPP-1:0]    pixIdx;

  function automatic logic [AW-1:0] stepAddr(input logic [AW-1:0] a);
    return (int'(a) == FRAME - 1) ? '0 : a + 1'b1;
  endfunction

  assign loadVal = (regWdata < DATA_W'(FRAME)) ? regWdata[AW-1:0] : '0;

  always_comb begin
    rdAddrNext = rdAddr;
    if (strobes.ldRdAddr) rdAddrNext = loadVal;
    else if (strobes.incRd) rdAddrNext = stepAddr(rdAddr);
  end

  always_comb begin
    wrAddrNext = wrAddr;
    if (strobes.ldWrAddr) wrAddrNext = loadVal;
    else if (strobes.wrVram) wrAddrNext = stepAddr(wrAddr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdAddr <= '0;
      wrAddr <= '0;
    end else begin
      rdAddr <= rdAddrNext;
      wrAddr <= wrAddrNext;
    end
  end

  // read channel looks one edge ahead so its output matches rdAddr
  assign vramRaddr = rdAddrNext;
  assign vramWe    = strobes.wrVram;
  assign vramWaddr = wrAddr;
  assign vramWdata = regWdata;

  // forward a write that hits the word the RAM is reading at the same edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bypassValid <= 1'b0;
      bypassWord  <= '0;
    end else begin
      bypassValid <= strobes.wrVram && (wrAddr == rdAddrNext);
      if (strobes.wrVram && (wrAddr == rdAddrNext)) bypassWord <= regWdata;
    end
  end

  // scan-out pixel extraction: position 0 is the most significant nibble
  assign scanShifted = scanWord >> (BPP * (PPW - 1 - int'(scanPixSel)));
  assign pixIdx      = scanShifted[BPP-1:0];

  fbrp_palette #(
    .IDX_W  (BPP),
    .COLOR_W(COLOR_W)
  ) u_palette (
    .clk       (clk),
    .rstN      (rstN),
    .selLd     (strobes.ldPalSel),
    .entryWr   (strobes.wrPal),
    .selValue  (regWdata[BPP-1:0]),
    .colorValue(regWdata[COLOR_W-1:0]),
    .lookIdx   (pixIdx),
    .lookRgb   (pixRgb)
  );

  always_comb begin
    statusWord = '0;
    statusWord[DATA_W-1 -: 4] = MODE_ID[3:0];
    statusWord[0] = vblank;
  end

  always_comb begin
    case (regAddr)
      OFS_RDADDR: regRdata = DATA_W'(rdAddr);
      OFS_WRADDR: regRdata = DATA_W'(wrAddr);
      OFS_DATA:   regRdata = bypassValid ? bypassWord : vramRdata;
      OFS_STATUS: regRdata = statusWord;
      default:    regRdata = '0;
    endcase
  end

  // R3: a data-port read advances the read latch by exactly one word
  assert_rd_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incRd && !strobes.ldRdAddr |=> rdAddr == stepAddr($past(rdAddr)));

  // R4: a data-port write advances the write latch by exactly one word
  assert_wr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrVram && !strobes.ldWrAddr |=> wrAddr == stepAddr($past(wrAddr)));

  // R5: the read latch holds when neither loaded nor read
  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.ldRdAddr && !strobes.incRd |=> $stable(rdAddr));

  // R5: the write latch holds when neither loaded nor written
  assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.ldWrAddr && !strobes.wrVram |=> $stable(wrAddr));

  // R6: both latches stay inside the frame
  assert_addr_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    int'(rdAddr) < FRAME && int'(wrAddr) < FRAME);

endmodule

// File: rtl/fb_reg_port.sv
module fb_reg_port
  import fbrp_pkg::*;
#(
  parameter int H_PIX   = 640,
  parameter int V_LINES = 400,
  parameter int BPP     = 4,
  parameter int DATA_W  = 32,
  parameter int COLOR_W = 12,
  parameter int MODE_ID = 1,
  localparam int PPW    = DATA_W / BPP,
  localparam int AW     = $clog2((H_PIX / PPW) * V_LINES),
  localparam int SELW   = $clog2(PPW)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         regAddr,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic               vblank,
  output logic               vramWe,
  output logic [AW-1:0]      vramWaddr,
  output logic [DATA_W-1:0]  vramWdata,
  output logic [AW-1:0]      vramRaddr,
  input  logic [DATA_W-1:0]  vramRdata,
  input  logic [DATA_W-1:0]  scanWord,
  input  logic [SELW-1:0]    scanPixSel,
  output logic [COLOR_W-1:0] pixRgb
);

  fbStrobes_t strobes;

  fbrp_ctrl u_ctrl (
    .regWr  (regWr),
    .regRd  (regRd),
    .regAddr(regAddr),
    .strobes(strobes)
  );

  fbrp_datapath #(
    .H_PIX  (H_PIX),
    .V_LINES(V_LINES),
    .BPP    (BPP),
    .DATA_W (DATA_W),
    .COLOR_W(COLOR_W),
    .MODE_ID(MODE_ID)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .vblank    (vblank),
    .vramWe    (vramWe),
    .vramWaddr (vramWaddr),
    .vramWdata (vramWdata),
    .vramRaddr (vramRaddr),
    .vramRdata (vramRdata),
    .scanWord  (scanWord),
    .scanPixSel(scanPixSel),
    .pixRgb    (pixRgb)
  );

endmodule

// File: tb/fb_reg_port_tb.sv
`timescale 1ns/1ps
module fb_reg_port_tb;

  localparam int H_PIX = 64, V_LINES = 4, WPL = 8, FRAME = 32, AW = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWdata = '0, regRdata;
  logic        vblank = 1'b0;
  logic        vramWe;
  logic [AW-1:0] vramWaddr, vramRaddr;
  logic [31:0] vramWdata, vramRdata;
  logic [31:0] scanWord = '0;
  logic [2:0]  scanPixSel = '0;
  logic [11:0] pixRgb;

  logic [31:0] mem [0:FRAME-1];
  logic [31:0] em  [0:FRAME-1];
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fb_reg_port #(.H_PIX(H_PIX), .V_LINES(V_LINES)) u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .vblank(vblank),
    .vramWe(vramWe), .vramWaddr(vramWaddr), .vramWdata(vramWdata),
    .vramRaddr(vramRaddr), .vramRdata(vramRdata),
    .scanWord(scanWord), .scanPixSel(scanPixSel), .pixRgb(pixRgb));

  // video RAM model: registered read, old data on a same-edge write
  always @(posedge clk) begin
    if (vramWe) mem[vramWaddr] <= vramWdata;
    vramRdata <= mem[vramRaddr];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input bit rd, input logic [2:0] a,
                     input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    regWr = wr; regRd = rd; regAddr = a; regWdata = d;
    #1 q = regRdata;
    @(posedge clk);
    #1 regWr = 1'b0; regRd = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int i);
    return (32'h9E3779B9 * (i + 1)) ^ 32'(i << 7);
  endfunction

  function automatic logic [11:0] palv(input int k);
    return {4'((k * 7 + 3) & 15), 4'((k * 11 + 5) & 15), 4'(15 - k)};
  endfunction

  task automatic lookup(input logic [31:0] w, input int p, output logic [11:0] c);
    @(negedge clk);
    scanWord = w; scanPixSel = 3'(p);
    @(negedge clk);
    #1 c = pixRgb;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] q;
    logic [11:0] c;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    acc(0, 1, 3'd0, 0, q); chk("R1 read address after reset", q, 0);
    acc(0, 1, 3'd1, 0, q); chk("R1 write address after reset", q, 0);
    lookup(32'h7654_3210, 3, c); chk("R1 palette zero after reset", 32'(c), 0);

    // R2: status register
    acc(0, 1, 3'd5, 0, q); chk("R2 status vblank low", q, 32'h1000_0000);
    vblank = 1'b1;
    acc(0, 1, 3'd5, 0, q); chk("R2 status vblank high", q, 32'h1000_0001);
    acc(1, 0, 3'd5, 32'hFFFF_FFFF, q);
    acc(0, 1, 3'd5, 0, q); chk("R2 status write ignored", q, 32'h1000_0001);
    acc(0, 1, 3'd0, 0, q); chk("R2 status write leaves read address", q, 0);
    vblank = 1'b0;

    // R4: fill whole frame back to back
    acc(1, 0, 3'd1, 0, q);
    for (int i = 0; i < FRAME; i++) begin
      acc(1, 0, 3'd2, pat(i), q);
      em[i] = pat(i);
    end
    // R6: write latch wrapped after the last word
    acc(0, 1, 3'd1, 0, q); chk("R6 write address wrap", q, 0);

    // R3: back-to-back reads over two passes of the frame
    acc(1, 0, 3'd0, 0, q);
    for (int i = 0; i < 2 * FRAME; i++) begin
      acc(0, 1, 3'd2, 0, q);
      chk($sformatf("R3 sequential read %0d", i), q, em[i % FRAME]);
    end
    acc(0, 1, 3'd0, 0, q); chk("R6 read address wrap", q, 0);

    // R5: line starts at WPL*n
    for (int n = 0; n < V_LINES; n++) begin
      acc(1, 0, 3'd0, 32'(WPL * n), q);
      acc(0, 1, 3'd2, 0, q); chk($sformatf("R5 line %0d start word", n), q, em[WPL * n]);
      acc(0, 1, 3'd0, 0, q); chk($sformatf("R5 line %0d address after read", n), q, 32'(WPL * n + 1));
    end

    // R6: out-of-range loads and last-word increment
    acc(1, 0, 3'd0, 32'd40, q);
    acc(0, 1, 3'd0, 0, q); chk("R6 read load out of range", q, 0);
    acc(1, 0, 3'd1, 32'd32, q);
    acc(0, 1, 3'd1, 0, q); chk("R6 write load out of range", q, 0);
    acc(1, 0, 3'd0, 32'd31, q);
    acc(0, 1, 3'd2, 0, q); chk("R6 read last word", q, em[31]);
    acc(0, 1, 3'd0, 0, q); chk("R6 read advance from last word", q, 0);
    acc(1, 0, 3'd1, 32'd31, q);
    acc(1, 0, 3'd2, 32'hCAFE_0031, q); em[31] = 32'hCAFE_0031;
    acc(0, 1, 3'd1, 0, q); chk("R6 write advance from last word", q, 0);

    // R4: write forwarded to an immediately following read
    acc(1, 0, 3'd0, 32'd5, q);
    acc(1, 0, 3'd1, 32'd5, q);
    acc(1, 0, 3'd2, 32'hDEAD_BEEF, q); em[5] = 32'hDEAD_BEEF;
    acc(0, 1, 3'd2, 0, q); chk("R4 read right after write same word", q, em[5]);
    acc(0, 1, 3'd2, 0, q); chk("R4 next word after forwarded read", q, em[6]);
    acc(0, 1, 3'd1, 0, q); chk("R4 write address advanced", q, 6);
    acc(1, 0, 3'd0, 32'd5, q);
    acc(0, 1, 3'd2, 0, q); chk("R4 written word from memory", q, em[5]);
    // R4: write to a different word leaves the prefetched word alone
    acc(1, 0, 3'd0, 32'd20, q);
    acc(1, 0, 3'd1, 32'd21, q);
    acc(1, 0, 3'd2, 32'h1234_5678, q); em[21] = 32'h1234_5678;
    acc(0, 1, 3'd2, 0, q); chk("R4 unrelated write keeps read word", q, em[20]);
    acc(0, 1, 3'd2, 0, q); chk("R4 following word sees write", q, em[21]);

    // R7: palette load with garbage in the upper bits
    for (int k = 0; k < 16; k++) begin
      acc(1, 0, 3'd3, 32'(k), q);
      acc(1, 0, 3'd4, {20'hABCDE, palv(k)}, q);
    end
    acc(0, 1, 3'd3, 0, q); chk("R7 palette select reads zero", q, 0);
    acc(0, 1, 3'd4, 0, q); chk("R7 palette data reads zero", q, 0);
    acc(0, 1, 3'd6, 0, q); chk("R7 offset 6 reads zero", q, 0);
    acc(0, 1, 3'd7, 0, q); chk("R7 offset 7 reads zero", q, 0);

    // R8: every index at every pixel position
    for (int k = 0; k < 16; k++) begin
      for (int p = 0; p < 8; p++) begin
        logic [31:0] w;
        w = '0;
        for (int s = 0; s < 8; s++)
          w[31 - 4 * s -: 4] = (s == p) ? 4'(k) : 4'((k + s + 3) & 15);
        if (((k + p + 3) & 15) == k) w = w;
        lookup(w, p, c);
        chk($sformatf("R8 index %0d position %0d", k, p), 32'(c), 32'(palv(k)));
      end
    end

    // R7: select uses only the low four bits
    acc(1, 0, 3'd3, 32'h0000_0012, q);
    acc(1, 0, 3'd4, 32'h0000_0ABC, q);
    lookup(32'h2000_0000, 0, c); chk("R7 reselected slot 2", 32'(c), 32'hABC);
    lookup(32'h0000_0003, 7, c); chk("R7 slot 3 untouched", 32'(c), 32'(palv(3)));

    summary();
  end

endmodule